// File: doc/BRIEF.md
# Dual Countdown Timer

This block holds two independent 32-bit down-counters behind one word-addressed register window. Software programs a reload value, picks periodic or single-shot operation, and enables an interrupt per counter. Each counter raises its own interrupt line when it expires. Each counter also keeps a sticky status flag that software clears by writing a one to it.

Each counter exposes six word registers. It has a live count, a reload value and a deferred reload value. The deferred reload value changes the next period but leaves the running count alone. Each counter also has a control word, a sticky expiry flag and the expiry flag gated by the interrupt enable. The counters decrement on a tick. The tick is every clock, or one clock in `PRESCALE` when that parameter is above one, and both counters share it.

Read data returns on `bus_rdata_o` with `bus_rvalid_o` high in the cycle after the read. Holding `bus_rd_i` high for consecutive cycles streams one response per cycle. The response has no ready signal and cannot be stalled, so the requester must accept every response. Writes take effect at the clock edge that samples them.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset every register of both counters reads zero, both counters are stopped and both interrupt lines are low.
- R2: The registers of counter 0 are at words 0 to 5 and those of counter 1 at words 6 to 11. Words 12 to 15 are reserved: writes to them change nothing and reads return zero. Every read response appears, with `bus_rvalid_o` high, in the cycle after the read.
- R3: Within a counter's block the word offsets are: 0 live count, 1 reload, 2 deferred reload, 3 control, 4 expiry flag, 5 gated flag. In the control word, bit 0 enables, bit 1 selects single-shot and bit 2 enables the interrupt. A control write with bit 0 set loads the count from the reload register, and the count then falls by one per tick.
- R4: A tick that finds the count at zero is an expiry and sets bit 0 of the expiry flag. In periodic mode the count reloads from the reload register, giving a period of reload+1 ticks.
- R5: In single-shot mode an expiry leaves the count at zero and stops it. No further expiry follows until software restarts the counter.
- R6: Writing 1 to bit 0 of the expiry flag clears it, and writing 0 leaves it unchanged. If an expiry happens in the same cycle as the clearing write, the flag stays set.
- R7: The gated flag and the interrupt line both equal the expiry flag AND the interrupt-enable bit.
- R8: A control write that clears bit 0 freezes the count at its present value, with no decrement in that cycle.
- R9: A write to the reload register while enabled loads the count with the new value immediately. While disabled, the same write only stores the value.
- R10: A write to the deferred reload register updates both the deferred and the reload registers, leaves the running count untouched, and sets the value used at the next reload.
- R11: Writes to the live count and the gated flag are ignored. Reading the live count returns the current count.
- R12: The two counters are independent. Activity on one never changes the other's registers or interrupt line.
- R13: With `PRESCALE` = N, an enabled count falls by exactly one for every N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W (4) | Word address |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read response data |
| bus_rvalid_o | output | 1 | Read response valid, one cycle after the read |
| irq_o | output | N_TIMERS (2) | Interrupt line per counter |

## Verification
A corrupted count shows up at the ports only through a read of the live-count word, one cycle after the read. Otherwise it appears when an interrupt comes a wrong number of ticks after a restart, so the checks read the count at exact cycle offsets from each control write. A lost or stuck expiry flag shows on `irq_o` in the cycle after the expiry, provided the enable bit is set. Reading the gated flag shows the same fault with interrupts off. A mis-decoded address shows as a changed register in the other counter, or as a nonzero read from the reserved words, on the next read.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int REGS_PER_TIMER = 6;

  typedef enum logic [2:0] {
    SEL_COUNT  = 3'd0,
    SEL_RELOAD = 3'd1,
    SEL_DEFER  = 3'd2,
    SEL_CTRL   = 3'd3,
    SEL_FLAG   = 3'd4,
    SEL_GATED  = 3'd5
  } reg_sel_e;

  // bit 0 enable, bit 1 single-shot, bit 2 interrupt enable
  typedef struct packed {
    logic irq_en;
    logic single;
    logic run_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick_o = (div_q == LAST);

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o || (DIV == 1)); // R13

endmodule

// File: rtl/window_decode.sv
module window_decode import timer_pkg::*; #(
  parameter int N_TIMERS = 2,
  parameter int ADDR_W   = 4,
  parameter int IDX_W    = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output reg_sel_e          sel_o
);

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    sel_o = SEL_COUNT;
    for (int i = 0; i < N_TIMERS; i++) begin
      if (int'(addr_i) >= i * REGS_PER_TIMER &&
          int'(addr_i) < (i + 1) * REGS_PER_TIMER) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        sel_o = reg_sel_e'(3'(int'(addr_i) - i * REGS_PER_TIMER));
      end
    end
  end

endmodule

// File: rtl/countdown_channel.sv
module countdown_channel import timer_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] count_q, reload_q, defer_q;
  ctrl_t            ctrl_q;
  logic             flag_q;
  logic             running_q;

  logic wr_ctrl, wr_reload, wr_defer, wr_flag;
  logic expire;

  assign wr_ctrl   = wr_i && (sel_i == SEL_CTRL);
  assign wr_reload = wr_i && (sel_i == SEL_RELOAD);
  assign wr_defer  = wr_i && (sel_i == SEL_DEFER);
  assign wr_flag   = wr_i && (sel_i == SEL_FLAG);

  assign expire = tick_i && running_q && (count_q == '0);

  // Count and run state: register writes take priority over the tick.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      running_q <= 1'b0;
    end else if (wr_ctrl) begin
      if (wdata_i[0]) begin
        count_q   <= reload_q;
        running_q <= 1'b1;
      end else begin
        running_q <= 1'b0;
      end
    end else if (wr_reload && ctrl_q.run_en) begin
      count_q   <= wdata_i;
      running_q <= 1'b1;
    end else if (expire) begin
      if (ctrl_q.single) begin
        running_q <= 1'b0;
      end else begin
        count_q <= reload_q;
      end
    end else if (tick_i && running_q) begin
      count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      defer_q  <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr_reload || wr_defer) reload_q <= wdata_i;
      if (wr_defer)              defer_q  <= wdata_i;
      if (wr_ctrl)               ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  // Sticky expiry flag: a set in the same cycle beats a clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end else if (wr_flag && wdata_i[0]) begin
      flag_q <= 1'b0;
    end
  end

  assign irq_o = flag_q && ctrl_q.irq_en;

  always_comb begin
    case (sel_i)
      SEL_COUNT:  rdata_o = count_q;
      SEL_RELOAD: rdata_o = reload_q;
      SEL_DEFER:  rdata_o = defer_q;
      SEL_CTRL:   rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      SEL_FLAG:   rdata_o = {{(CNT_W-1){1'b0}}, flag_q};
      SEL_GATED:  rdata_o = {{(CNT_W-1){1'b0}}, irq_o};
      default:    rdata_o = '0;
    endcase
  end

  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> flag_q); // R4
  AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && !ctrl_q.single && !wr_ctrl && !wr_reload |=> count_q == $past(reload_q)); // R4
  AST_SINGLE_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && ctrl_q.single && !wr_ctrl && !wr_reload |=> !running_q && count_q == '0); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flag && wdata_i[0] && !expire |=> !flag_q); // R6
  AST_FLAG_ZERO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flag && !wdata_i[0] |=> flag_q || !$past(flag_q) == 1'b0 ? flag_q : 1'b1); // R6
  AST_FROZEN_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_q && !wr_ctrl && !wr_reload |=> $stable(count_q)); // R8
  AST_DEFER_UPDATES_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_defer |=> reload_q == $past(wdata_i) && defer_q == $past(wdata_i)); // R10

endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer import timer_pkg::*; #(
  parameter int N_TIMERS = 2,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int PRESCALE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic [N_TIMERS-1:0] irq_o
);

  localparam int IDX_W  = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1;
  localparam int WINDOW = N_TIMERS * REGS_PER_TIMER;

  logic             hit;
  logic [IDX_W-1:0] idx;
  reg_sel_e         sel;
  logic             tick;
  logic [DATA_W-1:0] ch_rdata [N_TIMERS];
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  window_decode #(
    .N_TIMERS (N_TIMERS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr_i (bus_addr_i),
    .hit_o  (hit),
    .idx_o  (idx),
    .sel_o  (sel)
  );

  generate
    if (PRESCALE > 1) begin : g_prescale
      tick_prescaler #(.DIV(PRESCALE)) u_prescale (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
      );
    end else begin : g_every_clock
      assign tick = 1'b1;
    end
  endgenerate

  generate
    for (genvar i = 0; i < N_TIMERS; i++) begin : g_chan
      logic ch_wr;
      assign ch_wr = bus_wr_i && hit && (idx == IDX_W'(i));
      countdown_channel #(.CNT_W(DATA_W)) u_chan (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .wr_i    (ch_wr),
        .sel_i   (sel),
        .wdata_i (bus_wdata_i),
        .rdata_o (ch_rdata[i]),
        .irq_o   (irq_o[i])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd_i;
      if (bus_rd_i) rdata_q <= hit ? ch_rdata[idx] : '0;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i |=> bus_rvalid_o); // R2
  AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> !bus_rvalid_o); // R2
  AST_RESERVED_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && (int'(bus_addr_i) >= WINDOW) |=> bus_rdata_o == '0); // R2

endmodule

// File: tb/tb_dual_countdown_timer.sv
module tb_dual_countdown_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_ps;
  logic        rvalid, rvalid_ps;
  logic [1:0]  irq, irq_ps;

  always #4 clk = ~clk;

  dual_countdown_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_rvalid_o(rvalid), .irq_o(irq));

  dual_countdown_timer #(.PRESCALE(4)) dut_ps (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_ps),
    .bus_rvalid_o(rvalid_ps), .irq_o(irq_ps));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] ps_last, ps_first;

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected value for every read response.
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        chk(rdata, 32'hxxxx_xxxx, "R2 unexpected response");
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr_t(int a, logic [31:0] d);
    wr = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_t(int a, logic [31:0] e, string tag);
    rd = 1'b1; addr = 4'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
    ps_last = rdata_ps;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(32'(irq), 0, "R1 irq after reset");
    for (int a = 0; a < 16; a++) rd_t(a, 0, "R1 register zero after reset");

    // R13 prescaled rate, and R3 count loading/decrement on the plain instance
    wr_t(1, 100);
    wr_t(3, 1);
    rd_t(0, 100, "R3 count loaded by enable");
    ps_first = ps_last;
    idle(7);
    rd_t(0, 92, "R3 one decrement per clock");
    chk(ps_first - ps_last, 2, "R13 two ticks per eight clocks");
    wr_t(3, 0);

    // R9 reload write while disabled only stores
    wr_t(1, 5);
    rd_t(0, 91, "R9 disabled reload write keeps count");
    wr_t(3, 5);
    rd_t(0, 5, "R3 restart from reload");
    rd_t(0, 4, "R3 decrement");
    idle(4);
    chk(32'(irq), 2'b01, "R4 R7 R12 irq after expiry");
    rd_t(0, 5, "R4 periodic reload");
    rd_t(5, 1, "R7 gated flag");
    rd_t(4, 1, "R4 expiry flag set");
    wr_t(3, 4);
    rd_t(0, 2, "R8 frozen on disable");
    idle(3);
    rd_t(0, 2, "R8 still frozen");
    wr_t(4, 0);
    rd_t(4, 1, "R6 write zero no effect");
    wr_t(4, 1);
    chk(32'(irq), 0, "R6 R7 irq low after clear");
    rd_t(4, 0, "R6 flag cleared");

    // R6 set beats clear in the same cycle
    wr_t(1, 3);
    wr_t(3, 1);
    idle(3);
    wr_t(4, 1);
    rd_t(4, 1, "R6 set wins over clear");
    rd_t(5, 0, "R7 gated flag masked");
    chk(32'(irq), 0, "R7 irq masked");
    wr_t(3, 0);

    // R5 single-shot
    wr_t(4, 1);
    wr_t(1, 2);
    wr_t(3, 3);
    idle(10);
    rd_t(0, 0, "R5 single-shot holds zero");
    rd_t(4, 1, "R5 single-shot flag");
    wr_t(4, 1);
    idle(6);
    rd_t(4, 0, "R5 no second expiry");
    rd_t(0, 0, "R5 count stays zero");

    // R9 reload while enabled, R10 deferred reload, R11 ignored writes
    wr_t(3, 0);
    wr_t(1, 100);
    wr_t(3, 1);
    idle(2);
    wr_t(1, 50);
    rd_t(0, 50, "R9 immediate reload");
    wr_t(2, 7);
    rd_t(0, 48, "R10 count unaffected by deferred write");
    rd_t(1, 7, "R10 reload updated");
    rd_t(2, 7, "R10 deferred register");
    idle(46);
    rd_t(0, 7, "R10 new value at next reload");
    rd_t(0, 6, "R10 decrement after reload");
    wr_t(0, 32'hdead);
    rd_t(0, 4, "R11 count write ignored");
    wr_t(5, 1);
    rd_t(5, 0, "R11 gated flag write ignored");
    wr_t(3, 0);

    // R12 counter 1 independent
    wr_t(7, 4);
    wr_t(9, 5);
    idle(5);
    chk(32'(irq), 2'b10, "R12 only counter 1 interrupts");
    rd_t(10, 1, "R12 counter 1 flag");
    rd_t(11, 1, "R12 counter 1 gated");
    rd_t(3, 0, "R12 counter 0 control untouched");
    wr_t(9, 0);
    chk(32'(irq), 0, "R7 irq follows enable");
    rd_t(11, 0, "R7 gated follows enable");

    // R2 reserved words
    wr_t(12, 32'hffff_ffff);
    wr_t(15, 32'h1234);
    for (int a = 12; a < 16; a++) rd_t(a, 0, "R2 reserved reads zero");
    rd_t(7, 4, "R2 reserved write left counter 1");
    rd_t(1, 7, "R2 reserved write left counter 0");

    idle(3);
    if (exp_q.size() != 0) chk(32'(exp_q.size()), 0, "R2 missing responses");
    finish_run();
  end

endmodule